// File: doc/BRIEF.md
# Gear-Down Entry Sequencer

This block sits on the controller side of a DDR4-style command interface. It moves the command timing from 1N, where one clock carries a command, to 2N, where each command is held for two clocks. The move can happen in exactly two windows: once during initialization, and on each self-refresh exit. The block issues a relaxed-timing MRS that turns the gear-down setting on. It then issues a single-strobe sync pulse carried on a NOP, an even number of clocks after the MRS. After that it holds off two ready flags. One covers commands that need a locked DLL and one covers commands that do not, and each is released by its own programmable delay counted from the sync pulse.

The sequence starts from a one-cycle start request. A context input tells the block whether the start is an initialization or a self-refresh exit. A gear-down request, gated by a speed-grade allow input, selects 2N or plain 1N. The only legal way back to 1N is self-refresh entry. Any other request to leave 2N is refused and recorded in a sticky error flag. The command outputs are encoded as idle 0, MRS 1, NOP 2, REFRESH 3, and a command is valid only while the chip-select strobe is high.

Top module: `gear_entry_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, cmd_o is idle (0), cs_o is 0, and gear_2n_o, rdy_nodll_o, rdy_dll_o and err_o are 0.
- R2: An accepted initialization start in cycle k with 2N selected produces MRS (cmd 1, cs 1) in cycle k+1. It then produces the sync NOP (cmd 2, cs 1) S cycles after the MRS, where S is the programmed sync gap after rounding. cs_o stays 0 in between.
- R3: The sync gap S is the programmed t_sync_i rounded up to an even number, with a minimum of 2: 5 gives 6, and 0 or 1 give 2.
- R4: gear_2n_o rises in the cycle right after the sync NOP and not earlier.
- R5: rdy_nodll_o rises max(t_cmd_i,1) cycles after the sync NOP. rdy_dll_o rises max(D,1) cycles after it, where D is t_dllk_i for initialization and t_xsdll_i for self-refresh exit.
- R6: If 2N is not requested, or gd_allow_i is 0, at an initialization start in cycle k, no MRS or NOP is sent, gear_2n_o stays 0, and both ready flags are 1 in cycle k+1.
- R7: On a self-refresh exit start in cycle k with 2N selected, the MRS appears in cycle k+max(t_xs_i,1)+1. Before the MRS, ref_req_i gives REFRESH (cmd 3, cs 1) in the same cycle. Outside that wait, ref_req_i has no effect.
- R8: On a self-refresh exit start in cycle k with 1N selected, no MRS or NOP is sent, and both ready flags rise in cycle k+max(t_xs_i,1)+1.
- R9: sr_enter_i in cycle k makes gear_2n_o and both ready flags 0 in cycle k+1 and returns the block to idle.
- R10: leave_2n_i while gear_2n_o is 1 leaves gear_2n_o at 1 and sets err_o from the next cycle until reset. While gear_2n_o is 0, leave_2n_i does not set err_o.
- R11: A start is ignored when the block is not idle, when it is a second initialization start since reset, or when it is a self-refresh exit start with no self-refresh entry since the last accepted exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to run a sequence |
| srx_ctx_i | input | 1 | 0 = initialization, 1 = self-refresh exit |
| gd_want_i | input | 1 | Request 2N gear-down timing |
| gd_allow_i | input | 1 | Speed grade supports gear-down |
| sr_enter_i | input | 1 | Self-refresh entry, forces 1N |
| leave_2n_i | input | 1 | Request to drop to 1N by another route (refused) |
| ref_req_i | input | 1 | REFRESH request during the exit wait |
| t_xs_i | input | CNT_W | Self-refresh exit delay in cycles |
| t_sync_i | input | CNT_W | MRS-to-sync gap in cycles |
| t_cmd_i | input | CNT_W | Sync to DLL-independent command ready |
| t_dllk_i | input | CNT_W | Sync to DLL-dependent ready, initialization |
| t_xsdll_i | input | CNT_W | Sync to DLL-dependent ready, self-refresh exit |
| cmd_o | output | 2 | Command code: 0 idle, 1 MRS, 2 NOP, 3 REFRESH |
| cs_o | output | 1 | Chip-select strobe qualifying cmd_o |
| gear_2n_o | output | 1 | 1 while in 2N timing |
| rdy_nodll_o | output | 1 | Commands without DLL lock may issue |
| rdy_dll_o | output | 1 | Commands needing DLL lock may issue |
| err_o | output | 1 | Sticky refused-exit error |

## Verification
The MRS follows an accepted start by one cycle on initialization and by the exit delay plus one on self-refresh exit. The sync NOP follows the MRS by the rounded even gap, and REFRESH appears in the same cycle as its request. The gear flag changes one cycle after the sync NOP or after self-refresh entry, and each ready flag rises its own programmed delay after the sync. The bench works out the exact cycle index of every command strobe and queues it before the stimulus. A monitor then compares each observed strobe against the head of that queue, so a strobe that is early, late, wrong or extra is caught. Flag checks sample the cycle before and the cycle of each expected edge, which pins every delay to its exact value.

// File: rtl/gear_entry_pkg.sv
// Shared command and state encodings for the gear-down entry sequencer.
package gear_entry_pkg;
    // Command codes presented on cmd_o; valid only with cs_o high.
    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_MRS  = 2'd1,
        CMD_NOP  = 2'd2,
        CMD_REF  = 2'd3
    } gs_cmd_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_XS    = 3'd1,
        ST_MRS   = 3'd2,
        ST_SGAP  = 3'd3,
        ST_SYNC  = 3'd4,
        ST_RUN2N = 3'd5,
        ST_RUN1N = 3'd6
    } gs_state_e;
endpackage

// File: rtl/gs_even_gap.sv
// Rounds a programmed MRS-to-sync gap up to an even count, minimum 2.
// Assumes: pure combinational; output is one bit wider so rounding cannot wrap.
module gs_even_gap #(
    parameter int W = 8
) (
    input  logic [W-1:0] gap_i,
    output logic [W:0]   gap_o
);
    // Add the low bit to reach the next even value, then floor at 2.
    always_comb begin
        gap_o = {1'b0, gap_i} + (W + 1)'(gap_i[0]);
        if (gap_o < (W + 1)'(2)) begin
            gap_o = (W + 1)'(2);
        end
    end

    // Result must be even, at least 2 and never below the request.
    always_comb begin
        if (!$isunknown(gap_i)) begin
            p_even_gap_r3: assert (gap_o[0] == 1'b0 && gap_o >= (W + 1)'(2)
                                   && gap_o >= {1'b0, gap_i});
        end
    end
endmodule

// File: rtl/gs_timer.sv
// Loadable down-counter that stops at zero; zero_o flags expiry.
// Assumes: a load of value v reports zero_o exactly v+1 cycles later.
module gs_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    // Load on request, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/gear_entry_seq.sv
// Gear-down entry sequencer: drives MRS then an even-offset sync NOP to move
// the command interface from 1N to 2N on initialization or self-refresh exit,
// and releases separate ready flags for DLL-independent and DLL-dependent
// commands. Assumes timing inputs are stable while a sequence runs.
module gear_entry_seq
    import gear_entry_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             srx_ctx_i,
    input  logic             gd_want_i,
    input  logic             gd_allow_i,
    input  logic             sr_enter_i,
    input  logic             leave_2n_i,
    input  logic             ref_req_i,
    input  logic [CNT_W-1:0] t_xs_i,
    input  logic [CNT_W-1:0] t_sync_i,
    input  logic [CNT_W-1:0] t_cmd_i,
    input  logic [CNT_W-1:0] t_dllk_i,
    input  logic [CNT_W-1:0] t_xsdll_i,
    output logic [1:0]       cmd_o,
    output logic             cs_o,
    output logic             gear_2n_o,
    output logic             rdy_nodll_o,
    output logic             rdy_dll_o,
    output logic             err_o
);
    localparam int TW     = CNT_W + 1;
    localparam int NTIMER = 2;   // 0: step timer, 1: DLL window timer

    gs_state_e       st_q, st_nx;
    gs_cmd_e         cmd_e;
    logic            gear_q, err_q, inited_q, insr_q, srx_q, gd_q;
    logic            accept, gd_now;
    logic [TW-1:0]   s_even;
    logic [NTIMER-1:0] t_load, t_zero;
    logic [TW-1:0]   t_val [NTIMER];

    // Clamp a delay to at least 1 and return delay-1 as a timer load value.
    function automatic logic [TW-1:0] dly_m1(input logic [CNT_W-1:0] v);
        return (v == '0) ? '0 : (TW'(v) - 1'b1);
    endfunction

    assign gd_now = gd_want_i & gd_allow_i;
    assign accept = start_i && (st_q == ST_IDLE) && !sr_enter_i &&
                    ((!srx_ctx_i && !inited_q) || (srx_ctx_i && insr_q));

    gs_even_gap #(.W(CNT_W)) u_even (.gap_i(t_sync_i), .gap_o(s_even));

    // Two identical timers: one steps the sequence, one tracks the DLL window.
    for (genvar gi = 0; gi < NTIMER; gi++) begin : g_tmr
        gs_timer #(.W(TW)) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (t_load[gi]),
            .val_i  (t_val[gi]),
            .zero_o (t_zero[gi])
        );
    end

    // Select timer loads: exit delay, sync gap, then both ready delays.
    always_comb begin
        t_load   = '0;
        t_val[0] = '0;
        t_val[1] = dly_m1(srx_q ? t_xsdll_i : t_dllk_i);
        case (st_q)
            ST_IDLE: if (accept && srx_ctx_i) begin
                t_load[0] = 1'b1;
                t_val[0]  = dly_m1(t_xs_i);
            end
            ST_MRS: begin
                t_load[0] = 1'b1;
                t_val[0]  = s_even - TW'(2);
            end
            ST_SYNC: begin
                t_load    = '1;
                t_val[0]  = dly_m1(t_cmd_i);
            end
            default: ;
        endcase
    end

    // Next-state logic; self-refresh entry overrides everything.
    always_comb begin
        st_nx = st_q;
        case (st_q)
            ST_IDLE:  if (accept) st_nx = srx_ctx_i ? ST_XS : (gd_now ? ST_MRS : ST_RUN1N);
            ST_XS:    if (t_zero[0]) st_nx = gd_q ? ST_MRS : ST_RUN1N;
            ST_MRS:   st_nx = ST_SGAP;
            ST_SGAP:  if (t_zero[0]) st_nx = ST_SYNC;
            ST_SYNC:  st_nx = ST_RUN2N;
            default:  st_nx = st_q;
        endcase
        if (sr_enter_i) st_nx = ST_IDLE;
    end

    // State and context registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            inited_q <= 1'b0;
            insr_q   <= 1'b0;
            srx_q    <= 1'b0;
            gd_q     <= 1'b0;
        end else begin
            st_q <= st_nx;
            if (accept) begin
                srx_q <= srx_ctx_i;
                gd_q  <= gd_now;
                if (!srx_ctx_i) inited_q <= 1'b1;
                if (srx_ctx_i)  insr_q   <= 1'b0;
            end
            if (sr_enter_i) insr_q <= 1'b1;
        end
    end

    // Gear flag: set by the sync pulse, cleared only by self-refresh entry.
    always_ff @(posedge clk) begin
        if (!rst_n)              gear_q <= 1'b0;
        else if (sr_enter_i)     gear_q <= 1'b0;
        else if (st_q == ST_SYNC) gear_q <= 1'b1;
    end

    // Sticky error on a refused 2N exit request.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      err_q <= 1'b0;
        else if (leave_2n_i && gear_q && !sr_enter_i)    err_q <= 1'b1;
    end

    // Command decode from state; REFRESH passes only during the exit wait.
    always_comb begin
        cmd_e = CMD_IDLE;
        cs_o  = 1'b0;
        case (st_q)
            ST_MRS:  begin cmd_e = CMD_MRS; cs_o = 1'b1; end
            ST_SYNC: begin cmd_e = CMD_NOP; cs_o = 1'b1; end
            ST_XS:   if (ref_req_i) begin cmd_e = CMD_REF; cs_o = 1'b1; end
            default: ;
        endcase
    end

    assign cmd_o       = cmd_e;
    assign gear_2n_o   = gear_q;
    assign err_o       = err_q;
    assign rdy_nodll_o = (st_q == ST_RUN1N) || (st_q == ST_RUN2N && t_zero[0]);
    assign rdy_dll_o   = (st_q == ST_RUN1N) || (st_q == ST_RUN2N && t_zero[1]);

    // Cycles since the last MRS strobe, saturating; used only by checks.
    logic [TW:0] gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                          gap_q <= '0;
        else if (cmd_e == CMD_MRS)           gap_q <= (TW + 1)'(1);
        else if (gap_q != '1 && gap_q != '0) gap_q <= gap_q + 1'b1;
    end

    p_sync_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_NOP) |-> (gap_q[0] == 1'b0 && gap_q >= (TW + 1)'(2)));
    p_gear_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gear_2n_o) |-> ($past(cmd_o) == CMD_NOP && $past(cs_o)));
    p_gear_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gear_2n_o) |-> $past(sr_enter_i));
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
    p_ref_1n_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_REF) |-> !gear_2n_o);
endmodule

// File: tb/gear_entry_seq_bench.sv
`timescale 1ns/100ps
module gear_entry_seq_bench;
    import gear_entry_pkg::*;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, srx_ctx_i = 0, gd_want_i = 0, gd_allow_i = 0;
    logic sr_enter_i = 0, leave_2n_i = 0, ref_req_i = 0;
    logic [CNT_W-1:0] t_xs_i = 0, t_sync_i = 0, t_cmd_i = 0, t_dllk_i = 0, t_xsdll_i = 0;
    logic [1:0] cmd_o;
    logic cs_o, gear_2n_o, rdy_nodll_o, rdy_dll_o, err_o;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        int      at;
        gs_cmd_e cmd;
        string   tag;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gear_entry_seq #(.CNT_W(CNT_W)) u_gear_entry_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .srx_ctx_i(srx_ctx_i),
        .gd_want_i(gd_want_i), .gd_allow_i(gd_allow_i), .sr_enter_i(sr_enter_i),
        .leave_2n_i(leave_2n_i), .ref_req_i(ref_req_i), .t_xs_i(t_xs_i),
        .t_sync_i(t_sync_i), .t_cmd_i(t_cmd_i), .t_dllk_i(t_dllk_i),
        .t_xsdll_i(t_xsdll_i), .cmd_o(cmd_o), .cs_o(cs_o), .gear_2n_o(gear_2n_o),
        .rdy_nodll_o(rdy_nodll_o), .rdy_dll_o(rdy_dll_o), .err_o(err_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic push(input int at, input gs_cmd_e c, input string tag);
        exp_t e;
        e.at = at; e.cmd = c; e.tag = tag;
        q.push_back(e);
    endtask

    // Move to 1 ns after the falling edge that ends cycle c.
    task automatic at(input int c);
        while (cyc < c) @(negedge clk);
        #1;
    endtask

    // Monitor: every command strobe must match the head of the queue.
    initial forever begin
        @(negedge clk);
        #2;
        if (rst_n === 1'b1 && cs_o === 1'b1) begin
            if (q.size() == 0) begin
                check(1'b0, "R11 unexpected strobe cmd", int'(cmd_o), 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(cyc == e.at, {e.tag, " strobe cycle"}, cyc, e.at);
                check(cmd_o == e.cmd, {e.tag, " strobe cmd"}, int'(cmd_o), int'(e.cmd));
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog expired act=%0d exp=0", cyc);
        summary();
    end

    initial begin
        int k, n, j;
        do_reset();
        // R1: reset state
        check(cmd_o == 2'd0, "R1 cmd", int'(cmd_o), 0);
        check(cs_o == 1'b0, "R1 cs", cs_o, 0);
        check(gear_2n_o == 1'b0, "R1 gear", gear_2n_o, 0);
        check(rdy_nodll_o == 1'b0 && rdy_dll_o == 1'b0, "R1 ready", rdy_dll_o, 0);
        check(err_o == 1'b0, "R1 err", err_o, 0);

        // R2 R3 R4 R5: initialization into 2N, odd gap 5 rounds to 6
        k = cyc + 2;
        at(k);
        t_sync_i = 8'd5; t_cmd_i = 8'd3; t_dllk_i = 8'd10;
        gd_want_i = 1; gd_allow_i = 1; srx_ctx_i = 0; start_i = 1;
        push(k + 1, CMD_MRS, "R2");
        push(k + 7, CMD_NOP, "R3");
        at(k + 1); start_i = 0;
        at(k + 7);  check(gear_2n_o == 0, "R4 gear before", gear_2n_o, 0);
        at(k + 8);  check(gear_2n_o == 1, "R4 gear after", gear_2n_o, 1);
        at(k + 9);  check(rdy_nodll_o == 0, "R5 nodll early", rdy_nodll_o, 0);
        at(k + 10); check(rdy_nodll_o == 1, "R5 nodll due", rdy_nodll_o, 1);
        at(k + 16); check(rdy_dll_o == 0, "R5 dll early", rdy_dll_o, 0);
        at(k + 17); check(rdy_dll_o == 1, "R5 dll due", rdy_dll_o, 1);

        // R10: refused exit while in 2N
        at(k + 20); leave_2n_i = 1;
        at(k + 21); leave_2n_i = 0;
        at(k + 22);
        check(err_o == 1, "R10 err set", err_o, 1);
        check(gear_2n_o == 1, "R10 gear kept", gear_2n_o, 1);

        // R11: second init start and exit start without entry are ignored
        at(k + 24); srx_ctx_i = 0; start_i = 1;
        at(k + 25); srx_ctx_i = 1; start_i = 1;
        at(k + 26); start_i = 0;
        at(k + 30);
        check(gear_2n_o == 1, "R11 gear held", gear_2n_o, 1);
        check(rdy_dll_o == 1, "R11 ready held", rdy_dll_o, 1);
        check(q.size() == 0, "R11 queue", q.size(), 0);

        // R9: self-refresh entry drops to 1N
        at(k + 32); sr_enter_i = 1;
        at(k + 33); sr_enter_i = 0;
        check(gear_2n_o == 0, "R9 gear", gear_2n_o, 0);
        check(rdy_nodll_o == 0 && rdy_dll_o == 0, "R9 ready", rdy_nodll_o, 0);
        check(err_o == 1, "R10 err sticky", err_o, 1);

        // R7 R3 R5: self-refresh exit into 2N, gap 0 rounds to 2
        n = k + 36;
        at(n);
        t_xs_i = 8'd4; t_sync_i = 8'd0; t_cmd_i = 8'd1; t_xsdll_i = 8'd6;
        srx_ctx_i = 1; gd_want_i = 1; gd_allow_i = 1; start_i = 1;
        push(n + 2, CMD_REF, "R7");
        push(n + 5, CMD_MRS, "R7");
        push(n + 7, CMD_NOP, "R3");
        at(n + 1); start_i = 0;
        at(n + 2); ref_req_i = 1;
        at(n + 3); ref_req_i = 0;
        at(n + 7);  check(rdy_nodll_o == 0, "R5 srx nodll early", rdy_nodll_o, 0);
        at(n + 8);
        check(gear_2n_o == 1, "R4 srx gear", gear_2n_o, 1);
        check(rdy_nodll_o == 1, "R5 srx nodll due", rdy_nodll_o, 1);
        at(n + 12); check(rdy_dll_o == 0, "R5 srx dll early", rdy_dll_o, 0);
        at(n + 13); check(rdy_dll_o == 1, "R5 srx dll due", rdy_dll_o, 1);
        // R7: refresh request outside the exit wait has no effect
        at(n + 20); ref_req_i = 1;
        #0.5;
        check(cmd_o == 2'd0 && cs_o == 0, "R7 ref ignored", int'(cmd_o), 0);
        at(n + 21); ref_req_i = 0;

        // R6: init start with gear-down not allowed stays in 1N
        do_reset();
        k = cyc + 2;
        at(k);
        gd_want_i = 1; gd_allow_i = 0; srx_ctx_i = 0; start_i = 1;
        at(k + 1); start_i = 0;
        check(rdy_nodll_o == 1 && rdy_dll_o == 1, "R6 ready", rdy_dll_o, 1);
        check(gear_2n_o == 0, "R6 gear", gear_2n_o, 0);
        // R10: refused-exit request while in 1N raises no error
        at(k + 3); leave_2n_i = 1;
        at(k + 4); leave_2n_i = 0;
        at(k + 5); check(err_o == 0, "R10 no err in 1N", err_o, 0);

        // R8: self-refresh exit in 1N
        at(k + 6); sr_enter_i = 1;
        at(k + 7); sr_enter_i = 0;
        j = k + 9;
        at(j);
        t_xs_i = 8'd3; gd_want_i = 0; srx_ctx_i = 1; start_i = 1;
        at(j + 1); start_i = 0;
        at(j + 3); check(rdy_nodll_o == 0, "R8 ready early", rdy_nodll_o, 0);
        at(j + 4);
        check(rdy_nodll_o == 1 && rdy_dll_o == 1, "R8 ready due", rdy_dll_o, 1);
        check(gear_2n_o == 0, "R8 gear", gear_2n_o, 0);

        at(j + 8);
        check(q.size() == 0, "R2 all strobes seen", q.size(), 0);
        summary();
    end
endmodule